// File: doc/BRIEF.md
# Serial Control-Word Register Programmer

This block sits on the serial control port of a converter interface. It takes in 16-bit control words during secondary serial frames and writes them into a bank of eight 8-bit configuration registers. The serial shift clock `sclk` clocks the block. It shifts `din` in on falling edges while the secondary-frame indication is high. The word is accepted only when the sixteenth falling edge of that frame arrives. Words seen during primary frames are never treated as control traffic. If a frame ends early, its partial word is dropped.

A control word can also ask for a register to be read back. The value then leaves on `dout` during the next secondary frame. After reset, the serial output stays in high impedance while software runs its setup sequence. The output enable is granted on the rising edge of the eighth primary frame indication. Address 0 is a no-op, so software can send a harmless word, for example to shift frame timing. A register that should keep its reset value can simply be skipped.

Top module: `regprog_top`

## Requirements
- R1: Register contents change only at a falling `sclk` edge while `secFrame` is high. Words shifted in while only `primFrame` is high leave every register unchanged.
- R2: A control word takes effect on the sixteenth falling `sclk` edge of a secondary frame. After fifteen falling edges, the addressed register still holds its old value.
- R3: There are eight registers at addresses 1 to 8. After reset, each holds its default: reg1=0x19, reg2=0xC3, reg3=0x22, reg4=0xF0, reg5=0x07, reg6=0x81, reg7=0x3C, reg8=0x5A. On `regBus`, register n occupies bits [8n-1:8n-8].
- R4: A write to address 0 is a no-op and changes no register.
- R5: Word format, first bit on the wire = bit 15. Bit 15 selects read (1) or write (0). Bits 14:12 are ignored. Bits 11:8 hold the address. Bits 7:0 hold the data. A write to an address from 9 to 15 changes no register.
- R6: `doutOe` is low after reset. It rises with the rising `sclk` edge that first sees the eighth rising edge of `primFrame` since reset. It then stays high until the next reset.
- R7: After a read word, the following secondary frame shifts out the addressed register on `dout` as 16 bits, MSB first. The upper 8 bits are 0. A read word changes no register. Reading address 0 or an address above 8 returns zero.
- R8: `dout` is 0 whenever `secFrame` is low. During a secondary frame that does not follow a read word, `dout` is 0.
- R9: A secondary frame with fewer than sixteen falling edges is discarded and changes no register. The next full frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial shift clock; data sampled on falling edges |
| rstN | input | 1 | Asynchronous active-low reset |
| primFrame | input | 1 | High during a primary (conversion data) frame |
| secFrame | input | 1 | High during a secondary (control) frame |
| din | input | 1 | Serial data in, MSB first |
| dout | output | 1 | Serial data out (read-back) |
| doutOe | output | 1 | Output enable for the `dout` tri-state driver |
| regBus | output | 64 | Contents of registers 1..8, register n in bits [8n-1:8n-8] |

## Verification
The assertions check four things on every clock edge. Registers never change at an edge where `secFrame` is low. `dout` is quiet outside secondary frames. `doutOe` cannot rise before eight primary frame rises have been counted, and it never falls. Some behaviour depends on the word content and on where the sixteenth edge falls in a frame. The bench scenarios cover these cases: the exact commit edge, the no-op and out-of-range addresses, short frames, and the one-frame delay between a read request and its data on `dout`.

// File: rtl/regprog_pkg.sv
package regprog_pkg;
  // Strobes issued by the control section to the datapath each falling edge
  typedef struct packed {
    logic shiftIn;   // sample din into the receive shifter
    logic commit;    // sixteenth bit of a secondary frame: act on the word
    logic shiftOut;  // advance the transmit shifter
  } strobe_t;
endpackage

// File: rtl/regprog_ctrl.sv
module regprog_ctrl
  import regprog_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int SETUP_FRAMES = 8
) (
  input  logic    sclk,
  input  logic    rstN,
  input  logic    primFrame,
  input  logic    secFrame,
  output strobe_t strobes,
  output logic    doutOe
);
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int PCNT_W = $clog2(SETUP_FRAMES + 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [PCNT_W-1:0] primCnt;
  logic              primPrev;
  logic              primRise;

  // Bit position inside the current secondary frame; saturates at WORD_W so
  // bits after the sixteenth are ignored, and clears whenever the frame drops.
  always_ff @(negedge sclk or negedge rstN) begin
    if (!rstN)
      bitCnt <= '0;
    else if (!secFrame)
      bitCnt <= '0;
    else if (bitCnt < CNT_W'(WORD_W))
      bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strobes.shiftIn  = secFrame && (bitCnt < CNT_W'(WORD_W));
    strobes.commit   = strobes.shiftIn && (bitCnt == CNT_W'(WORD_W - 1));
    strobes.shiftOut = secFrame;
  end

  // Primary frame-sync rises are counted on rising sclk edges
  assign primRise = primFrame && !primPrev;

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      primPrev <= 1'b0;
      primCnt  <= '0;
      doutOe   <= 1'b0;
    end else begin
      primPrev <= primFrame;
      if (primRise && (primCnt < PCNT_W'(SETUP_FRAMES)))
        primCnt <= primCnt + 1'b1;
      if (primRise && (primCnt == PCNT_W'(SETUP_FRAMES - 1)))
        doutOe <= 1'b1;
    end
  end
endmodule

// File: rtl/regprog_dp.sv
module regprog_dp
  import regprog_pkg::*;
#(
  parameter int                       NUM_REGS = 8,
  parameter int                       DATA_W   = 8,
  parameter int                       ADDR_W   = 4,
  parameter int                       WORD_W   = 16,
  parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS = '0
) (
  input  logic                       sclk,
  input  logic                       rstN,
  input  logic                       din,
  input  logic                       secFrame,
  input  strobe_t                    strobes,
  output logic                       dout,
  output logic [NUM_REGS*DATA_W-1:0] regBus
);
  localparam int RD_BIT   = WORD_W - 1;
  localparam int ADDR_LSB = DATA_W;

  logic [WORD_W-1:0] inShift;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] outShift;
  logic [ADDR_W-1:0] wAddr;
  logic [DATA_W-1:0] wData;
  logic              isRead;
  logic [DATA_W-1:0] rdData;

  // Complete word as of the current falling edge (newest bit from din)
  assign word   = {inShift[WORD_W-2:0], din};
  assign isRead = word[RD_BIT];
  assign wAddr  = word[ADDR_LSB +: ADDR_W];
  assign wData  = word[DATA_W-1:0];

  always_ff @(negedge sclk or negedge rstN) begin
    if (!rstN)
      inShift <= '0;
    else if (strobes.shiftIn)
      inShift <= word;
  end

  // Register bank, one slice per address 1..NUM_REGS
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] value;
    logic              hit;
    assign hit = strobes.commit && !isRead && (wAddr == ADDR_W'(g + 1));
    always_ff @(negedge sclk or negedge rstN) begin
      if (!rstN)
        value <= DEFAULTS[g*DATA_W +: DATA_W];
      else if (hit)
        value <= wData;
    end
    assign regBus[g*DATA_W +: DATA_W] = value;
  end

  // Read-back mux; no-op and out-of-range addresses read as zero
  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (wAddr == ADDR_W'(i + 1))
        rdData = regBus[i*DATA_W +: DATA_W];
  end

  // Transmit shifter: loaded at each commit, drained in the next frame
  always_ff @(negedge sclk or negedge rstN) begin
    if (!rstN)
      outShift <= '0;
    else if (strobes.commit)
      outShift <= isRead ? {{(WORD_W-DATA_W){1'b0}}, rdData} : '0;
    else if (strobes.shiftOut)
      outShift <= {outShift[WORD_W-2:0], 1'b0};
  end

  assign dout = secFrame && outShift[WORD_W-1];
endmodule

// File: rtl/regprog_top.sv
module regprog_top #(
  parameter int                       NUM_REGS     = 8,
  parameter int                       DATA_W       = 8,
  parameter int                       ADDR_W       = 4,
  parameter int                       WORD_W       = 16,
  parameter int                       SETUP_FRAMES = 8,
  parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS   = 64'h5A3C8107F022C319
) (
  input  logic                       sclk,
  input  logic                       rstN,
  input  logic                       primFrame,
  input  logic                       secFrame,
  input  logic                       din,
  output logic                       dout,
  output logic                       doutOe,
  output logic [NUM_REGS*DATA_W-1:0] regBus
);
  regprog_pkg::strobe_t strobes;

  regprog_ctrl #(
    .WORD_W      (WORD_W),
    .SETUP_FRAMES(SETUP_FRAMES)
  ) u_ctrl (
    .sclk     (sclk),
    .rstN     (rstN),
    .primFrame(primFrame),
    .secFrame (secFrame),
    .strobes  (strobes),
    .doutOe   (doutOe)
  );

  regprog_dp #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .WORD_W  (WORD_W),
    .DEFAULTS(DEFAULTS)
  ) u_dp (
    .sclk    (sclk),
    .rstN    (rstN),
    .din     (din),
    .secFrame(secFrame),
    .strobes (strobes),
    .dout    (dout),
    .regBus  (regBus)
  );
endmodule

// File: rtl/regprog_checker.sv
module regprog_checker #(
  parameter int NUM_REGS     = 8,
  parameter int DATA_W       = 8,
  parameter int SETUP_FRAMES = 8
) (
  input logic                       sclk,
  input logic                       rstN,
  input logic                       primFrame,
  input logic                       secFrame,
  input logic                       dout,
  input logic                       doutOe,
  input logic [NUM_REGS*DATA_W-1:0] regBus
);
  localparam int PCNT_W = $clog2(SETUP_FRAMES + 1);

  logic [PCNT_W-1:0] riseSeen;
  logic              primLast;

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      riseSeen <= '0;
      primLast <= 1'b0;
    end else begin
      primLast <= primFrame;
      if (primFrame && !primLast && riseSeen < PCNT_W'(SETUP_FRAMES))
        riseSeen <= riseSeen + 1'b1;
    end
  end

  AST_NO_WRITE_OUTSIDE_SEC: assert property (@(negedge sclk) disable iff (!rstN)
    !secFrame |=> $stable(regBus)); // R1

  AST_DOUT_QUIET: assert property (@(negedge sclk) disable iff (!rstN)
    !secFrame |-> (dout == 1'b0)); // R8

  AST_OE_HELD_IN_SETUP: assert property (@(posedge sclk) disable iff (!rstN)
    (riseSeen < PCNT_W'(SETUP_FRAMES)) |-> !doutOe); // R6

  AST_OE_NEVER_DROPS: assert property (@(posedge sclk) disable iff (!rstN)
    !$fell(doutOe)); // R6
endmodule

bind regprog_top regprog_checker #(
  .NUM_REGS    (NUM_REGS),
  .DATA_W      (DATA_W),
  .SETUP_FRAMES(SETUP_FRAMES)
) u_chk (
  .sclk     (sclk),
  .rstN     (rstN),
  .primFrame(primFrame),
  .secFrame (secFrame),
  .dout     (dout),
  .doutOe   (doutOe),
  .regBus   (regBus)
);

// File: tb/regprog_top_test.sv
module regprog_top_test;
  localparam int CLK_PERIOD = 20;

  logic        sclk = 1'b0;
  logic        rstN = 1'b0;
  logic        primFrame = 1'b0;
  logic        secFrame = 1'b0;
  logic        din = 1'b0;
  logic        dout;
  logic        doutOe;
  logic [63:0] regBus;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] model [1:8];
  bit done = 0;

  regprog_top uut (
    .sclk(sclk), .rstN(rstN), .primFrame(primFrame), .secFrame(secFrame),
    .din(din), .dout(dout), .doutOe(doutOe), .regBus(regBus)
  );

  always #(CLK_PERIOD/2) sclk = ~sclk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] modelBus();
    logic [63:0] b;
    for (int n = 1; n <= 8; n++) b[(n-1)*8 +: 8] = model[n];
    return b;
  endfunction

  task automatic startFrame(input bit sec);
    @(posedge sclk); #1;
    if (sec) secFrame = 1'b1; else primFrame = 1'b1;
  endtask

  task automatic pushBit(input logic b, output logic got);
    din = b;
    #1 got = dout;
    @(negedge sclk);
    @(posedge sclk); #1;
  endtask

  task automatic endFrame();
    secFrame = 1'b0; primFrame = 1'b0; din = 1'b0;
    @(posedge sclk); #1;
  endtask

  task automatic sendFrame(input logic [15:0] w, input int nBits, input bit sec, output logic [15:0] got);
    logic b;
    got = '0;
    startFrame(sec);
    for (int i = 0; i < nBits; i++) begin
      pushBit(w[15-i], b);
      got[15-i] = b;
    end
    endFrame();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge sclk);
    #1 rstN = 1'b1;
    model[1] = 8'h19; model[2] = 8'hC3; model[3] = 8'h22; model[4] = 8'hF0;
    model[5] = 8'h07; model[6] = 8'h81; model[7] = 8'h3C; model[8] = 8'h5A;
  endtask

  task automatic testReset();
    #1;
    check(regBus == modelBus(), "R3 defaults", regBus, modelBus());
    check(doutOe == 1'b0, "R6 oe low after reset", doutOe, 0);
    check(dout == 1'b0, "R8 dout idle", dout, 0);
  endtask

  // Setup sequence: primary/secondary pairs, writing every register
  task automatic testSetup();
    logic [15:0] got;
    for (int n = 1; n <= 8; n++) begin
      sendFrame(16'h0000, 16, 1'b0, got);
      if (n == 7) check(doutOe == 1'b0, "R6 oe low after 7 primaries", doutOe, 0);
      if (n == 8) check(doutOe == 1'b1, "R6 oe high after 8th primary", doutOe, 1);
      if (n != 5) begin // register 5 keeps its default
        sendFrame({4'h0, 4'(n), 8'(8'hA0 + n)}, 16, 1'b1, got);
        model[n] = 8'(8'hA0 + n);
      end
      check(regBus == modelBus(), "R2 setup write", regBus, modelBus());
    end
    sendFrame(16'h0000, 16, 1'b0, got);
    check(doutOe == 1'b1, "R6 oe stays high", doutOe, 1);
  endtask

  task automatic testNoop();
    logic [15:0] got;
    sendFrame(16'h00FF, 16, 1'b1, got);
    check(regBus == modelBus(), "R4 address 0 no-op", regBus, modelBus());
  endtask

  task automatic testOutOfRange();
    logic [15:0] got;
    sendFrame(16'h0955, 16, 1'b1, got);
    sendFrame(16'h0FAA, 16, 1'b1, got);
    check(regBus == modelBus(), "R5 addresses 9..15 ignored", regBus, modelBus());
    sendFrame(16'h7266, 16, 1'b1, got); // bits 14:12 ignored
    model[2] = 8'h66;
    check(regBus == modelBus(), "R5 reserved bits ignored", regBus, modelBus());
  endtask

  task automatic testPrimaryIgnored();
    logic [15:0] got;
    sendFrame(16'h0311, 16, 1'b0, got);
    check(regBus == modelBus(), "R1 primary frame no write", regBus, modelBus());
  endtask

  task automatic testCommitEdge();
    logic [15:0] w;
    logic b;
    w = 16'h04C7;
    startFrame(1'b1);
    for (int i = 0; i < 15; i++) pushBit(w[15-i], b);
    check(regBus == modelBus(), "R2 no change after 15 edges", regBus, modelBus());
    pushBit(w[0], b);
    model[4] = 8'hC7;
    check(regBus == modelBus(), "R2 change on 16th edge", regBus, modelBus());
    pushBit(1'b1, b); pushBit(1'b0, b); // extra bits ignored
    endFrame();
    check(regBus == modelBus(), "R2 extra bits ignored", regBus, modelBus());
  endtask

  task automatic testShortFrame();
    logic [15:0] got;
    sendFrame(16'h0677, 10, 1'b1, got);
    check(regBus == modelBus(), "R9 short frame dropped", regBus, modelBus());
    sendFrame(16'h0678, 16, 1'b1, got);
    model[6] = 8'h78;
    check(regBus == modelBus(), "R9 next full frame accepted", regBus, modelBus());
  endtask

  task automatic testReadBack();
    logic [15:0] got;
    sendFrame(16'h83FF, 16, 1'b1, got);
    check(got == 16'h0000, "R8 dout zero without prior read", got, 0);
    check(regBus == modelBus(), "R7 read changes nothing", regBus, modelBus());
    sendFrame(16'h8500, 16, 1'b1, got);
    check(got == {8'h00, model[3]}, "R7 readback reg3", got, {8'h00, model[3]});
    sendFrame(16'h0000, 16, 1'b1, got);
    check(got == {8'h00, model[5]}, "R7 readback reg5 default", got, {8'h00, model[5]});
    sendFrame(16'h0000, 16, 1'b1, got);
    check(got == 16'h0000, "R8 dout zero after non-read", got, 0);
    sendFrame(16'h8C00, 16, 1'b1, got);
    sendFrame(16'h0000, 16, 1'b1, got);
    check(got == 16'h0000, "R7 out-of-range reads zero", got, 0);
  endtask

  initial begin
    doReset();
    testReset();
    testSetup();
    testNoop();
    testOutOfRange();
    testPrimaryIgnored();
    testCommitEdge();
    testShortFrame();
    testReadBack();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge sclk);
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule